// File: doc/BRIEF.md
# UART Register Front End with Prioritised Interrupt

This block is the software-visible side of a simple 16550-style serial port. A word-wide bus slave exposes eight registers. Received bytes land in a single holding register; there is no FIFO. Transmitted bytes leave through a valid/ready byte stream. The serial shifter, the baud generator and the modem pins sit outside the block. It keeps the line-status bits and drives one interrupt line, which it resolves from four sources in a fixed priority.

Two small state machines carry the behaviour. The transmit side has two states. `TX_EMPTY` moves to `TX_PEND` when the bus writes the data register. `TX_PEND` returns to `TX_EMPTY` when the consumer raises `tx_ready`. The receive side also has two states. `RX_EMPTY` moves to `RX_FULL` when a byte arrives. `RX_FULL` returns to `RX_EMPTY` when the bus reads the data register and no new byte arrives in that cycle. A byte arriving in `RX_FULL` with no read in that cycle keeps the state and raises overrun.

Top module: `uart_reg_front`

Register index is `bus_addr[5:2]`. The indices are:

| Index | Register | Access |
|---|---|---|
| 0 | data | read: receive; write: transmit |
| 1 | interrupt enable | read/write |
| 2 | interrupt identification | read only |
| 3 | line control | read/write |
| 4 | modem control | read/write |
| 5 | line status | read only |
| 6 | modem status | read/write |
| 7 | divisor | read/write |

Bit layouts:
- Interrupt enable: bit0 receive data, bit1 transmit empty, bit2 line error, bit3 modem status.
- Line status: bit0 data ready, bit1 overrun, bit2 parity, bit3 framing, bit4 break, bit5 transmit-holding empty, bit6 transmitter empty.

## Requirements
- R1: After reset, every register reads 0 except line status, which reads 0x60, and identification, which reads 0x01. Also after reset, `irq`=0, `tx_valid`=0 and `rx_ready`=1.
- R2: A read returns its data on `bus_rdata` one cycle after the read edge. Interrupt enable keeps bits [3:0], line control, modem control and modem status keep bits [7:0], and divisor keeps bits [15:0]. Each reads back what was written, with the upper bits zero.
- R3: Writes to identification (2), line status (5) or any index 8..15 change no state. Reads of indices 8..15 return 0.
- R4: In `TX_EMPTY`, a data write makes `tx_valid`=1 and `tx_byte`=`bus_wdata[7:0]` in the next cycle, and clears line-status bits 5 and 6. The byte is held until the edge where `tx_ready` is high, after which `tx_valid`=0.
- R5: A data write while in `TX_PEND` is ignored and `tx_byte` is unchanged.
- R6: A byte presented with `rx_valid` sets data ready and drops `rx_ready` in the next cycle. A data read returns that byte and clears data ready.
- R7: A byte arriving while data ready is set stores the new byte and sets overrun (bit1). If a data read happens in the same cycle, the read returns the old byte, no overrun is flagged, and data ready stays set.
- R8: The arrival flags `rx_perr`, `rx_ferr` and `rx_brk` set line-status bits 2, 3 and 4. A line-status read returns the bits and then clears bits 1..4. An error that arrives in the same cycle as that read survives the read.
- R9: Identification is resolved in this order. Line error enabled with any of bits 1..4 set gives 0x06. Receive enabled with data ready gives 0x04. Transmit enabled with holding empty gives 0x02. Modem enabled with any of modem-status bits [3:0] set gives 0x00. Otherwise it is 0x01.
- R10: `irq` is 1 exactly when identification is not 0x01. It follows any register change in the cycle right after that change's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits [5:2] give the register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Transmit consumer accepts the byte |
| tx_byte | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_ready | output | 1 | Holding register is free |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error for this byte |
| rx_ferr | input | 1 | Framing error for this byte |
| rx_brk | input | 1 | Break detected with this byte |

## Verification
Every state change lands at the edge that samples the stimulus. The bench drives on the falling edge and samples after the next rising edge, so `tx_valid`, `tx_byte`, `rx_ready` and `irq` are checked half a cycle after the edge that caused them. `bus_rdata` is registered, so read data is sampled in that same half cycle after the read edge. `irq` has no added delay beyond the register update. The check right after the interrupt-enable write therefore exercises the next-cycle timing of R10, before identification is read back. The sweeps cover all 256 transmit and receive byte values, all eight error-flag combinations, and all 256 combinations of enable mask and source state, each starting from a fresh reset.

// File: rtl/uart_front_pkg.sv
package uart_front_pkg;

    typedef enum logic [2:0] {
        REG_DATA  = 3'd0,
        REG_IEN   = 3'd1,
        REG_IID   = 3'd2,
        REG_LCTL  = 3'd3,
        REG_MCTL  = 3'd4,
        REG_LSTAT = 3'd5,
        REG_MSTAT = 3'd6,
        REG_DIV   = 3'd7
    } reg_idx_e;

    localparam int NUM_REGS = 8;

    // interrupt enable bits
    localparam int IE_RX = 0;
    localparam int IE_TX = 1;
    localparam int IE_LS = 2;
    localparam int IE_MS = 3;

    // error vector order inside the block: overrun, parity, framing, break
    localparam int ERR_OE = 0;
    localparam int ERR_PE = 1;
    localparam int ERR_FE = 2;
    localparam int ERR_BI = 3;

    localparam logic [2:0] IID_NONE  = 3'b001;
    localparam logic [2:0] IID_LINE  = 3'b110;
    localparam logic [2:0] IID_RXD   = 3'b100;
    localparam logic [2:0] IID_THRE  = 3'b010;
    localparam logic [2:0] IID_MODEM = 3'b000;

    typedef enum logic {TX_EMPTY, TX_PEND} tx_state_e;
    typedef enum logic {RX_EMPTY, RX_FULL} rx_state_e;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_front_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_empty
);

    tx_state_e   state_q, state_n;
    logic [DATA_W-1:0] byte_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_EMPTY;
            byte_q  <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == TX_EMPTY && load) begin
                byte_q <= load_byte;
            end
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            TX_EMPTY: if (load)     state_n = TX_PEND;
            TX_PEND:  if (tx_ready) state_n = TX_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        tx_valid = (state_q == TX_PEND);
        tx_empty = (state_q == TX_EMPTY);
        tx_byte  = byte_q;
    end

    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    assert_tx_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && load) |=> $stable(tx_byte));

    assert_tx_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && load) |=> (tx_valid && !tx_empty));

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_front_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              take_data,
    input  logic              take_status,
    output logic              rx_ready,
    output logic              data_ready,
    output logic [DATA_W-1:0] hold_byte,
    output logic [3:0]        err_bits
);

    rx_state_e   state_q, state_n;
    logic [DATA_W-1:0] byte_q;
    logic [3:0]  err_q, err_n;
    logic        overrun;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
            byte_q  <= '0;
            err_q   <= '0;
        end else begin
            state_q <= state_n;
            err_q   <= err_n;
            if (rx_valid) begin
                byte_q <= rx_byte;
            end
        end
    end

    // next state and sticky error bits
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            RX_EMPTY: if (rx_valid)               state_n = RX_FULL;
            RX_FULL:  if (take_data && !rx_valid) state_n = RX_EMPTY;
        endcase

        overrun = rx_valid && (state_q == RX_FULL) && !take_data;

        err_n = take_status ? 4'b0000 : err_q;
        if (rx_valid) begin
            err_n[ERR_OE] = err_n[ERR_OE] | overrun;
            err_n[ERR_PE] = err_n[ERR_PE] | rx_perr;
            err_n[ERR_FE] = err_n[ERR_FE] | rx_ferr;
            err_n[ERR_BI] = err_n[ERR_BI] | rx_brk;
        end
    end

    // outputs
    always_comb begin
        data_ready = (state_q == RX_FULL);
        rx_ready   = (state_q == RX_EMPTY);
        hold_byte  = byte_q;
        err_bits   = err_q;
    end

    assert_arrive_sets_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (data_ready && !rx_ready && hold_byte == $past(rx_byte)));

    assert_read_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_data && !rx_valid) |=> !data_ready);

    assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && data_ready && !take_data) |=> err_bits[ERR_OE]);

    assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_status && !rx_valid) |=> (err_bits == 4'b0000));

endmodule

// File: rtl/uart_irq_resolve.sv
module uart_irq_resolve
    import uart_front_pkg::*;
(
    input  logic [3:0] ien,
    input  logic       err_any,
    input  logic       data_ready,
    input  logic       thr_empty,
    input  logic [3:0] modem_low,
    output logic [2:0] iid,
    output logic       irq
);

    always_comb begin
        if (err_any && ien[IE_LS]) begin
            iid = IID_LINE;
        end else if (data_ready && ien[IE_RX]) begin
            iid = IID_RXD;
        end else if (thr_empty && ien[IE_TX]) begin
            iid = IID_THRE;
        end else if ((|modem_low) && ien[IE_MS]) begin
            iid = IID_MODEM;
        end else begin
            iid = IID_NONE;
        end
        irq = (iid != IID_NONE);
    end

endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
    import uart_front_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BUS_W  = 32,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]    idx;
    logic                idx_known;
    logic [NUM_REGS-1:0] wr_sel, rd_sel;

    logic [3:0]        ien_q;
    logic [DATA_W-1:0] lctl_q, mctl_q, msr_q;
    logic [DIV_W-1:0]  div_q;
    logic [BUS_W-1:0]  rdata_q, rd_value;

    logic              data_ready, tx_empty;
    logic [DATA_W-1:0] hold_byte;
    logic [3:0]        rx_err;
    logic [2:0]        iid;
    logic [7:0]        lstat;
    logic              unused_bits;

    assign idx         = bus_addr[ADDR_W-1:2];
    assign idx_known   = (32'(idx) < 32'(NUM_REGS));
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:DIV_W]};

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_decode
        assign wr_sel[k] = bus_sel &&  bus_we && (idx == IDX_W'(k));
        assign rd_sel[k] = bus_sel && !bus_we && (idx == IDX_W'(k));
    end

    uart_tx_hold #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_sel[REG_DATA]),
        .load_byte (bus_wdata[DATA_W-1:0]),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .tx_empty  (tx_empty)
    );

    uart_rx_hold #(.DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .rx_perr     (rx_perr),
        .rx_ferr     (rx_ferr),
        .rx_brk      (rx_brk),
        .take_data   (rd_sel[REG_DATA]),
        .take_status (rd_sel[REG_LSTAT]),
        .rx_ready    (rx_ready),
        .data_ready  (data_ready),
        .hold_byte   (hold_byte),
        .err_bits    (rx_err)
    );

    uart_irq_resolve u_irq (
        .ien        (ien_q),
        .err_any    (|rx_err),
        .data_ready (data_ready),
        .thr_empty  (tx_empty),
        .modem_low  (msr_q[3:0]),
        .iid        (iid),
        .irq        (irq)
    );

    // plain storage registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= '0;
            lctl_q <= '0;
            mctl_q <= '0;
            msr_q  <= '0;
            div_q  <= '0;
        end else begin
            if (wr_sel[REG_IEN])   ien_q  <= bus_wdata[3:0];
            if (wr_sel[REG_LCTL])  lctl_q <= bus_wdata[DATA_W-1:0];
            if (wr_sel[REG_MCTL])  mctl_q <= bus_wdata[DATA_W-1:0];
            if (wr_sel[REG_MSTAT]) msr_q  <= bus_wdata[DATA_W-1:0];
            if (wr_sel[REG_DIV])   div_q  <= bus_wdata[DIV_W-1:0];
        end
    end

    assign lstat = {1'b0, tx_empty, tx_empty, rx_err[ERR_BI], rx_err[ERR_FE],
                    rx_err[ERR_PE], rx_err[ERR_OE], data_ready};

    // read multiplexer
    always_comb begin
        rd_value = '0;
        if (idx_known) begin
            unique case (reg_idx_e'(idx[2:0]))
                REG_DATA:  rd_value[DATA_W-1:0] = hold_byte;
                REG_IEN:   rd_value[3:0]        = ien_q;
                REG_IID:   rd_value[2:0]        = iid;
                REG_LCTL:  rd_value[DATA_W-1:0] = lctl_q;
                REG_MCTL:  rd_value[DATA_W-1:0] = mctl_q;
                REG_LSTAT: rd_value[7:0]        = lstat;
                REG_MSTAT: rd_value[DATA_W-1:0] = msr_q;
                REG_DIV:   rd_value[DIV_W-1:0]  = div_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_sel && !bus_we) begin
            rdata_q <= rd_value;
        end
    end

    assign bus_rdata = rdata_q;

    assert_line_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rx_err) && ien_q[IE_LS]) |-> (iid == IID_LINE && irq));

    assert_modem_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iid == IID_MODEM) |-> (ien_q[IE_MS] && !(data_ready && ien_q[IE_RX])
                                && !(tx_empty && ien_q[IE_TX])));

    assert_unknown_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !idx_known) |=> ($stable(ien_q) && $stable(div_q)
            && $stable(msr_q) && $stable(lctl_q) && $stable(mctl_q) && $stable(tx_valid)));

    assert_idle_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == 4'b0000) |-> !irq);

endmodule

// File: tb/test_uart_reg_front.sv
module test_uart_reg_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, tx_valid, rx_ready;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    uart_reg_front i_uart_reg_front (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tx_ready = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic bus_write(input int idx, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'(idx * 4); bus_wdata = d;
        step();
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input int idx, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 6'(idx * 4);
        step();
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rx_send(input logic [7:0] b, input logic pe, input logic fe, input logic bi);
        rx_valid = 1'b1; rx_byte = b; rx_perr = pe; rx_ferr = fe; rx_brk = bi;
        step();
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic read_arrive(input int idx, input logic [7:0] b, input logic pe,
                               output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 6'(idx * 4);
        rx_valid = 1'b1; rx_byte = b; rx_perr = pe;
        step();
        bus_sel = 1'b0; rx_valid = 1'b0; rx_perr = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] expect_iid(input logic [3:0] ien, input bit err,
                                               input bit dr, input bit thre, input bit ms);
        if (err && ien[2])       return 32'h06;
        else if (dr && ien[0])   return 32'h04;
        else if (thre && ien[1]) return 32'h02;
        else if (ms && ien[3])   return 32'h00;
        else                     return 32'h01;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state, R3 unknown indices read zero
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 tx_valid", 32'(tx_valid), 32'h0);
        check("R1 rx_ready", 32'(rx_ready), 32'h1);
        for (int i = 0; i < 16; i++) begin
            bus_read(i, rd);
            if (i == 5)      check("R1 lstat", rd, 32'h60);
            else if (i == 2) check("R1 iid", rd, 32'h01);
            else if (i < 8)  check("R1 reg", rd, 32'h0);
            else             check("R3 unknown read", rd, 32'h0);
        end

        // R2 storage registers with width masks
        for (int p = 0; p < 4; p++) begin
            logic [31:0] pat;
            pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'hA5C3_5A3C :
                  (p == 2) ? 32'h1234_8001 : 32'h0;
            bus_write(1, pat); bus_write(3, pat ^ 32'h11);
            bus_write(4, pat ^ 32'h22); bus_write(6, pat & 32'hFFFF_FFF0);
            bus_write(7, pat ^ 32'h4444);
            bus_read(1, rd); check("R2 ien", rd, pat & 32'hF);
            bus_read(3, rd); check("R2 lctl", rd, (pat ^ 32'h11) & 32'hFF);
            bus_read(4, rd); check("R2 mctl", rd, (pat ^ 32'h22) & 32'hFF);
            bus_read(6, rd); check("R2 mstat", rd, pat & 32'hF0);
            bus_read(7, rd); check("R2 div", rd, (pat ^ 32'h4444) & 32'hFFFF);
        end
        bus_write(1, 32'h0); bus_write(6, 32'h0);

        // R3 writes to read-only and unknown indices have no effect
        bus_write(3, 32'h5A); bus_write(7, 32'hBEEF);
        bus_write(2, 32'hFF); bus_write(5, 32'hFF);
        for (int i = 8; i < 16; i++) bus_write(i, 32'hFFFF_FFFF);
        check("R3 no tx launch", 32'(tx_valid), 32'h0);
        check("R3 irq quiet", 32'(irq), 32'h0);
        bus_read(5, rd); check("R3 lstat", rd, 32'h60);
        bus_read(2, rd); check("R3 iid", rd, 32'h01);
        bus_read(1, rd); check("R3 ien", rd, 32'h0);
        bus_read(3, rd); check("R3 lctl", rd, 32'h5A);
        bus_read(6, rd); check("R3 mstat", rd, 32'h0);
        bus_read(7, rd); check("R3 div", rd, 32'hBEEF);

        // R4 and R5 transmit sweep over all byte values
        for (int b = 0; b < 256; b++) begin
            bus_write(0, {8'(b ^ 8'h5A), 8'hC3, 8'h77, 8'(b)});
            check("R4 tx_valid", 32'(tx_valid), 32'h1);
            check("R4 tx_byte", 32'(tx_byte), 32'(b));
            if (b % 32 == 0) begin
                bus_read(5, rd); check("R4 lstat pending", rd, 32'h00);
            end
            step();
            check("R4 hold", 32'(tx_byte), 32'(b));
            bus_write(0, 32'(~b));
            check("R5 ignored write", 32'(tx_byte), 32'(b));
            tx_ready = 1'b1;
            step();
            tx_ready = 1'b0;
            check("R4 drained", 32'(tx_valid), 32'h0);
        end
        bus_read(5, rd); check("R4 lstat empty", rd, 32'h60);

        // R6 receive sweep
        for (int b = 0; b < 256; b++) begin
            rx_send(8'(b), 1'b0, 1'b0, 1'b0);
            check("R6 rx_ready low", 32'(rx_ready), 32'h0);
            if (b % 32 == 0) begin
                bus_read(5, rd); check("R6 lstat dr", rd, 32'h61);
            end
            bus_read(0, rd); check("R6 data", rd, 32'(b));
            check("R6 rx_ready high", 32'(rx_ready), 32'h1);
        end
        bus_read(5, rd); check("R6 dr cleared", rd, 32'h60);

        // R7 overrun, then read racing an arrival
        rx_send(8'h11, 1'b0, 1'b0, 1'b0);
        rx_send(8'h22, 1'b0, 1'b0, 1'b0);
        bus_read(5, rd); check("R7 overrun set", rd, 32'h63);
        bus_read(5, rd); check("R8 overrun cleared", rd, 32'h61);
        bus_read(0, rd); check("R7 newest byte", rd, 32'h22);
        rx_send(8'h33, 1'b0, 1'b0, 1'b0);
        read_arrive(0, 8'h44, 1'b0, rd); check("R7 race old byte", rd, 32'h33);
        bus_read(5, rd); check("R7 race no overrun", rd, 32'h61);
        bus_read(0, rd); check("R7 race new byte", rd, 32'h44);

        // R8 error flag sweep
        for (int e = 0; e < 8; e++) begin
            rx_send(8'(e), e[0], e[1], e[2]);
            bus_read(5, rd); check("R8 flags", rd, 32'h61 | 32'(e << 2));
            bus_read(5, rd); check("R8 flags cleared", rd, 32'h61);
            bus_read(0, rd); check("R8 data", rd, 32'(e));
        end
        read_arrive(5, 8'h9C, 1'b1, rd); check("R8 race read value", rd, 32'h60);
        bus_read(5, rd); check("R8 race error kept", rd, 32'h65);
        bus_read(0, rd);

        // R9 and R10 priority sweep over enable mask and source state
        for (int c = 0; c < 256; c++) begin
            logic [3:0] ien;
            bit err, dr, thre, ms;
            logic [31:0] exp;
            ien = 4'(c); err = c[4]; dr = c[5]; thre = c[6]; ms = c[7];
            do_reset();
            if (err) begin
                rx_send(8'h5A, 1'b1, 1'b0, 1'b0);
                bus_read(0, rd);
            end
            if (dr) rx_send(8'hA5, 1'b0, 1'b0, 1'b0);
            if (!thre) bus_write(0, 32'h3C);
            bus_write(6, ms ? 32'hFF : 32'hF0);
            bus_write(1, 32'(ien));
            exp = expect_iid(ien, err, dr, thre, ms);
            check("R10 irq next cycle", 32'(irq), (exp != 32'h01) ? 32'h1 : 32'h0);
            bus_read(2, rd); check("R9 iid", rd, exp);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule